// File: doc/BRIEF.md
# Divided Clock Duty Monitor

This block supervises a clock that an external generator produces by dividing a fast source clock by eight. It runs only on that source clock. Each source cycle it takes one sample of the divided clock, after a two-stage synchronizer. Over a window that spans a whole number of output periods, it counts how many of those samples were high. A healthy divided clock gives half the window length. When the count strays from that value by more than a set tolerance, the block marks a fault and sends the generator a reset pulse of fixed width.

The generator's lock indication is not trusted as a health signal. A high lock status never suppresses a fault decision. The block uses lock only as a gate: while lock is low, counting is frozen at zero. After each reset pulse, counting stays suspended until lock has been high for a programmable number of consecutive cycles. This gives the generator time to re-acquire before it is judged again. A sticky fault flag and a saturating count of issued requests are brought out for the system.

Top module: `clkdiv_duty_monitor`

## Requirements
- R1: One judgement window spans WIN_LEN = 8 × WIN_PERIODS source cycles, with WIN_PERIODS from 1 to 4 (default 2, so 16). Exactly one synchronized sample of the divided clock is counted per enabled cycle.
- R2: At the end of a window, a fault is declared only when |ones − WIN_LEN/2| > TOL. TOL defaults to WIN_PERIODS (one sample per eight), so a deviation of exactly TOL is accepted.
- R3: A high lock status does not suppress the fault decision. A wrong duty cycle with lock high still produces a reset request.
- R4: A divided clock that is slowed by a source step of about 40 to 60 MHz is flagged. In source cycles, this clock has a period of 12, high for 10.
- R5: Each reset request is a pulse of exactly PULSE_LEN source cycles (default 4, never below 4). It begins the cycle after the faulty window's result is registered.
- R6: After a pulse ends, no window is judged until lock has been high for HOLDOFF consecutive cycles (default 16). A low lock restarts that count. With a stuck divided clock, the next pulse appears exactly HOLDOFF + WIN_LEN + 1 cycles after lock rises.
- R7: While lock is low, the sample and window counters are held at zero, so no fault or request can arise.
- R8: The fault flag stays high from the first fault until the system reset.
- R9: The request counter rises by one at the start of each pulse and saturates at 2^CNT_W − 1 (15 by default).
- R10: A synchronous active-low reset clears the fault flag, the request output and the request counter, and arms the monitor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock, eight times the divided frequency |
| rst_n | input | 1 | Synchronous active-low system reset |
| div_clk_in | input | 1 | Divided clock under supervision (asynchronous to sampling) |
| gen_locked | input | 1 | Lock status reported by the clock generator |
| gen_reset_req | output | 1 | Reset pulse to the clock generator |
| fault_flag | output | 1 | Sticky duty-cycle fault indication |
| reset_req_count | output | CNT_W | Saturating number of reset pulses issued |

## Verification
The embedded properties watch these rules on every cycle:
- the minimum width of the reset pulse,
- the sticky fault flag,
- the counter moving only in step with a rising request and holding once saturated,
- the window counters collapsing to zero whenever counting is disabled,
- the sample count never exceeding the samples taken.

Only the bench scenarios can show the following:
- the accept/reject decision at the tolerance boundary across duty patterns, including the slowed post-step clock;
- that a high lock status does not mask a fault;
- the exact delay from lock rising to the next request, including a restart of the hold-off count.

// File: rtl/dmon_pkg.sv
// Shared types for the divided clock duty monitor.
package dmon_pkg;

    // Supervisor state: judging windows, driving the reset pulse, waiting for re-lock.
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_PULSE = 2'd1,
        ST_HOLD  = 2'd2
    } mon_state_e;

    // Number of source samples in one judgement window.
    function automatic int win_samples(input int periods);
        return 8 * periods;
    endfunction

endpackage

// File: rtl/dmon_sync.sv
// Multi-stage synchronizer that brings the divided clock into the source domain.
// Assumes: the input is asynchronous to clk; STAGES >= 2.
module dmon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/dmon_window.sv
// Window sampler: counts high samples over WIN_LEN enabled cycles and registers
// the total with a one-cycle done strobe.
// Assumes: en low holds both counters at zero; a new window starts when en rises.
module dmon_window #(
    parameter int WIN_LEN = 16,
    localparam int CW = $clog2(WIN_LEN),
    localparam int OW = $clog2(WIN_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          sample,
    output logic          done,
    output logic [OW-1:0] ones_total
);

    localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);

    logic [CW-1:0] win_cnt;
    logic [OW-1:0] ones;
    logic          at_last;

    assign at_last = (win_cnt == LAST);

    // Advance the position in the window and accumulate high samples.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            win_cnt <= '0;
            ones    <= '0;
        end else if (at_last) begin
            win_cnt <= '0;
            ones    <= '0;
        end else begin
            win_cnt <= win_cnt + CW'(1);
            ones    <= ones + OW'(sample);
        end
    end

    // Register the completed window total and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            ones_total <= '0;
        end else begin
            done <= en && at_last;
            if (en && at_last) ones_total <= ones + OW'(sample);
        end
    end

    // R7
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (win_cnt == '0 && ones == '0));

    // R1
    ones_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= OW'(win_cnt));

endmodule

// File: rtl/dmon_supervisor.sv
// Supervisor: judges each window total against half the window, issues the
// reset pulse, waits out the re-lock hold-off, keeps the sticky fault and count.
// Assumes: TOL < WIN_LEN/2, PULSE_LEN >= 4, HOLDOFF >= 1.
module dmon_supervisor
    import dmon_pkg::*;
#(
    parameter int WIN_LEN   = 16,
    parameter int TOL       = 2,
    parameter int PULSE_LEN = 4,
    parameter int HOLDOFF   = 16,
    parameter int CNT_W     = 4,
    localparam int OW = $clog2(WIN_LEN + 1),
    localparam int PW = $clog2(PULSE_LEN + 1),
    localparam int HW = $clog2(HOLDOFF + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             locked,
    input  logic             win_done,
    input  logic [OW-1:0]    ones_total,
    output logic             armed,
    output logic             req,
    output logic             fault,
    output logic [CNT_W-1:0] req_count
);

    localparam logic [OW-1:0]    HALF    = OW'(WIN_LEN / 2);
    localparam logic [OW-1:0]    TOL_V   = OW'(TOL);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    mon_state_e    state;
    logic [PW-1:0] pulse_cnt;
    logic [HW-1:0] hold_cnt;
    logic [OW-1:0] dev;
    logic          bad_window;

    // Distance of the window total from the ideal half-window count.
    always_comb begin
        dev        = (ones_total > HALF) ? (ones_total - HALF) : (HALF - ones_total);
        bad_window = win_done && (dev > TOL_V);
    end

    // Sequence judging, pulsing and re-lock waiting; keep flag and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_ARMED;
            pulse_cnt <= '0;
            hold_cnt  <= '0;
            fault     <= 1'b0;
            req_count <= '0;
        end else begin
            case (state)
                ST_ARMED: begin
                    if (bad_window) begin
                        state     <= ST_PULSE;
                        pulse_cnt <= PW'(PULSE_LEN);
                        fault     <= 1'b1;
                        if (req_count != CNT_MAX) req_count <= req_count + CNT_W'(1);
                    end
                end
                ST_PULSE: begin
                    pulse_cnt <= pulse_cnt - PW'(1);
                    if (pulse_cnt == PW'(1)) begin
                        state    <= ST_HOLD;
                        hold_cnt <= '0;
                    end
                end
                default: begin
                    if (!locked)                         hold_cnt <= '0;
                    else if (hold_cnt == HW'(HOLDOFF - 1)) state  <= ST_ARMED;
                    else                                 hold_cnt <= hold_cnt + HW'(1);
                end
            endcase
        end
    end

    assign armed = (state == ST_ARMED);
    assign req   = (pulse_cnt != '0);

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> ($past(req, 2) && $past(req, 3) && $past(req, 4)));

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(req_count) |-> ($rose(req) && req_count == CNT_W'($past(req_count) + CNT_W'(1))));

    // R9
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_count == CNT_MAX) |=> (req_count == CNT_MAX));

    // R6
    rise_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> ($past(state) == ST_ARMED));

endmodule

// File: rtl/clkdiv_duty_monitor.sv
// Top: supervises a divide-by-eight clock using the fast source clock that feeds
// its generator, and requests a generator reset on a bad duty cycle.
// Assumes: everything runs on clk_src; div_clk_in is asynchronous to it.
module clkdiv_duty_monitor #(
    parameter int WIN_PERIODS = 2,
    parameter int TOL         = WIN_PERIODS,
    parameter int PULSE_LEN   = 4,
    parameter int HOLDOFF     = 16,
    parameter int CNT_W       = 4,
    localparam int WIN_LEN = dmon_pkg::win_samples(WIN_PERIODS),
    localparam int OW      = $clog2(WIN_LEN + 1)
) (
    input  logic             clk_src,
    input  logic             rst_n,
    input  logic             div_clk_in,
    input  logic             gen_locked,
    output logic             gen_reset_req,
    output logic             fault_flag,
    output logic [CNT_W-1:0] reset_req_count
);

    logic          div_sync;
    logic          armed;
    logic          win_en;
    logic          win_done;
    logic [OW-1:0] ones_total;

    // Count only while the generator reports lock and the supervisor is judging.
    assign win_en = gen_locked && armed;

    dmon_sync #(.STAGES(2)) u_sync (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .d_async (div_clk_in),
        .q_sync  (div_sync)
    );

    dmon_window #(.WIN_LEN(WIN_LEN)) u_window (
        .clk        (clk_src),
        .rst_n      (rst_n),
        .en         (win_en),
        .sample     (div_sync),
        .done       (win_done),
        .ones_total (ones_total)
    );

    dmon_supervisor #(
        .WIN_LEN   (WIN_LEN),
        .TOL       (TOL),
        .PULSE_LEN (PULSE_LEN),
        .HOLDOFF   (HOLDOFF),
        .CNT_W     (CNT_W)
    ) u_sup (
        .clk        (clk_src),
        .rst_n      (rst_n),
        .locked     (gen_locked),
        .win_done   (win_done),
        .ones_total (ones_total),
        .armed      (armed),
        .req        (gen_reset_req),
        .fault      (fault_flag),
        .req_count  (reset_req_count)
    );

endmodule

// File: tb/clkdiv_duty_monitor_tb.sv
// Bench: table of duty patterns walked by one loop, then directed tests.
module clkdiv_duty_monitor_tb;

    localparam int WIN_LEN   = 16;
    localparam int PULSE_LEN = 4;
    localparam int HOLDOFF   = 16;
    localparam int CNT_W     = 4;
    localparam int NV        = 9;

    // Pattern table: high cycles, low cycles, expected fault (window 16, tolerance 2).
    localparam int VEC_HI [NV] = '{4, 5, 3, 8, 6, 2, 10, 16, 0};
    localparam int VEC_LO [NV] = '{4, 3, 5, 8, 2, 6,  2,  0, 16};
    localparam int VEC_EX [NV] = '{0, 0, 0, 0, 1, 1,  1,  1,  1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic div_clk = 1'b0;
    logic locked = 1'b0;
    wire  req;
    wire  fault;
    wire  [CNT_W-1:0] cnt;

    int n_chk = 0;
    int n_fail = 0;
    int pat_hi = 4;
    int pat_lo = 4;
    int ph = 0;

    clkdiv_duty_monitor u_dut (
        .clk_src         (clk),
        .rst_n           (rst_n),
        .div_clk_in      (div_clk),
        .gen_locked      (locked),
        .gen_reset_req   (req),
        .fault_flag      (fault),
        .reset_req_count (cnt)
    );

    always #10 clk = ~clk;

    // Divided clock model: pat_hi high cycles then pat_lo low cycles.
    always @(negedge clk) begin
        if (pat_hi + pat_lo == 0) begin
            div_clk <= 1'b0;
        end else begin
            div_clk <= (ph < pat_hi);
            ph <= (ph + 1 >= pat_hi + pat_lo) ? 0 : ph + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        locked = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_req(output int cyc);
        cyc = 0;
        while (req !== 1'b1 && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        int wid;
        int seen;

        // R10: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 req after reset", req, 0);
        chk("R10 fault after reset", fault, 0);
        chk("R10 count after reset", cnt, 0);

        // R1 R2 R3 R4: pattern table with lock held high
        for (int v = 0; v < NV; v++) begin
            pat_hi = VEC_HI[v];
            pat_lo = VEC_LO[v];
            do_reset();
            locked = 1'b1;
            repeat (60) @(negedge clk);
            chk($sformatf("R2/R3/R4 fault vec%0d", v), fault, VEC_EX[v]);
            chk($sformatf("R1/R3 request issued vec%0d", v), (cnt != 0) ? 1 : 0, VEC_EX[v]);
        end

        // R7: lock low keeps the monitor silent despite a stuck clock
        pat_hi = 0; pat_lo = 16;
        do_reset();
        seen = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (req) seen = 1;
        end
        chk("R7 no request while unlocked", seen, 0);
        chk("R7 no fault while unlocked", fault, 0);

        // R5: pulse width; drop lock on the first request cycle
        locked = 1'b1;
        wait_req(cyc);
        locked = 1'b0;
        wid = 0;
        while (req) begin
            wid++;
            @(negedge clk);
        end
        chk("R5 pulse width", wid, PULSE_LEN);

        // R6: no further request while lock stays low
        seen = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (req) seen = 1;
        end
        chk("R6 held off while unlocked", seen, 0);
        chk("R9 single request counted", cnt, 1);

        // R6 R1: exact delay from lock rising to the next request
        locked = 1'b1;
        wait_req(cyc);
        chk("R6 hold-off plus window delay", cyc, HOLDOFF + WIN_LEN + 1);
        locked = 1'b0;
        repeat (10) @(negedge clk);

        // R6: a lock drop restarts the hold-off count
        locked = 1'b1;
        repeat (8) @(negedge clk);
        locked = 1'b0;
        @(negedge clk);
        locked = 1'b1;
        wait_req(cyc);
        chk("R6 restarted hold-off delay", cyc, HOLDOFF + WIN_LEN + 1);
        chk("R9 three requests counted", cnt, 3);

        // R8 R2: healthy clock afterwards leaves the flag set and issues nothing
        pat_hi = 4; pat_lo = 4;
        repeat (150) @(negedge clk);
        chk("R8 fault stays set", fault, 1);
        chk("R2 healthy clock adds no request", cnt, 3);

        // R9: saturation under a permanently stuck clock
        pat_hi = 0; pat_lo = 16;
        repeat (1000) @(negedge clk);
        chk("R9 counter saturated", cnt, 15);
        repeat (200) @(negedge clk);
        chk("R9 counter holds at max", cnt, 15);

        // R10: reset clears flag and counter
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 fault cleared", fault, 0);
        chk("R10 count cleared", cnt, 0);
        chk("R10 request cleared", req, 0);
        rst_n = 1'b1;

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule